// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI host reach a bank of sixteen 8-bit registers held by the timekeeping logic. The host frames each transaction by holding chip select high. The first byte is a command. It carries a read flag in bit 7, a fixed pattern in bits 6..4 and a register address in bits 3..0. Every byte after the command is data. Each data byte moves the register pointer on by one, so a single frame can sweep through neighbouring registers, for example all seven time and date registers in one go.

SCK, chip select and MOSI are brought into the system clock domain through a two-flop synchroniser. SCK edges are then found by comparing the synchronised level with a copy one cycle older. On the register side the block drives a plain register-file port. For a write it presents an address, write data and a one-cycle write strobe. For a read it presents an address and a one-cycle read strobe, and it captures `reg_rdata` in that same cycle. A read is fetched when the command byte or the previous data byte completes. Its first bit is therefore on MISO before the host's first sampling edge. One consequence is that a read frame always fetches one register beyond the last byte the host clocks out.

The control state machine has five states. IDLE is the state while chip select is low. CMD is entered from IDLE when chip select rises, and it collects the command byte. When the command byte completes, CMD goes to WRITE for a valid write command, to READ for a valid read command, and to IGNORE for a command with a bad fixed pattern. From every state, chip select going low returns the machine to IDLE.

Top module: `spireg_slave`

## Requirements
- R1: While reset is held, `spi_miso`, `reg_wr` and `reg_rd` are all 0.
- R2: Chip select is active high. While it is low, `spi_miso` is 0, and SCK or MOSI activity produces no register strobe.
- R3: A command is valid only when its bits 6..4 are 001. Bit 7 = 1 selects a read, bit 7 = 0 selects a write, and bits 3..0 give the start address. Valid writes are therefore 0x10 to 0x1F and valid reads are 0x90 to 0x9F.
- R4: After a write command, each completed data byte produces exactly one `reg_wr` pulse. The pulse carries the byte in `reg_wdata` and the current address in `reg_addr`. The byte is assembled MSB first from MOSI, sampled on the rising edges of SCK.
- R5: After a read command, the register at the current address is strobed with `reg_rd` and returned on MISO MSB first. MISO advances on the falling edges of SCK. The first bit is valid at the first rising edge of the data byte.
- R6: Within a frame, the address advances by one after each strobe and wraps from 0xF to 0x0.
- R7: After an invalid command, the rest of the frame produces no strobe, and MISO stays 0 until chip select falls.
- R8: A data byte that is cut short by chip select falling is discarded and writes nothing.
- R9: MISO is 0 throughout the command byte.
- R10: `reg_wr` and `reg_rd` are never high together. The block is specified for SCK phases of at least 4 system clock cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | ADDR_W | Register address for the current strobe |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is captured in this cycle |
| reg_rdata | input | 8 | Read data returned by the register file |

## Verification
If the register pointer holds a wrong value, the fault shows on `reg_addr` at the next strobe, at most one byte time after the data byte that caused it. If the state machine takes a wrong branch after the command, an unexpected `reg_wr` or `reg_rd` pulse appears, or MISO carries non-zero bits, within the first data byte. A slip in the transmit shift register corrupts the MISO byte the host samples in the same frame. For that reason the bench sweeps all 256 command values and all sixteen burst start points, and it compares every returned byte against a register image it keeps itself.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int BYTE_W      = 8;
    localparam int CMD_RD_BIT  = 7;
    localparam logic [2:0] CMD_FIXED = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } spireg_state_e;

    function automatic logic cmd_valid(input logic [BYTE_W-1:0] c);
        return c[6:4] == CMD_FIXED;
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spireg_rx.sv
module spireg_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] byte_q,
    output logic         done
);

    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sr     <= '0;
            byte_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (sample) begin
                sr <= {sr[W-2:0], din};
                if (cnt == CW'(W - 1)) begin
                    cnt    <= '0;
                    done   <= 1'b1;
                    byte_q <= {sr[W-2:0], din};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spireg_tx.sv
module spireg_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         enable,
    output logic         dout
);

    logic [W-1:0] sr;
    logic         skip;

    // The falling edge right after a load keeps the MSB on the line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            skip <= 1'b0;
        end else if (clear) begin
            sr   <= '0;
            skip <= 1'b0;
        end else if (load) begin
            sr   <= load_data;
            skip <= 1'b1;
        end else if (shift) begin
            if (skip) begin
                skip <= 1'b0;
            end else begin
                sr <= {sr[W-2:0], 1'b0};
            end
        end
    end

    assign dout = enable & sr[W-1];

endmodule

// File: rtl/spireg_fsm.sv
module spireg_fsm
    import spireg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                byte_done,
    input  logic [BYTE_W-1:0]   rx_byte,
    output spireg_state_e       state,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [BYTE_W-1:0]   reg_wdata,
    output logic                reg_wr,
    output logic                reg_rd
);

    spireg_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs) nxt = ST_CMD;
            end
            ST_CMD: begin
                if (!cs) begin
                    nxt = ST_IDLE;
                end else if (byte_done) begin
                    if (!cmd_valid(rx_byte)) begin
                        nxt = ST_IGNORE;
                    end else if (rx_byte[CMD_RD_BIT]) begin
                        nxt = ST_READ;
                    end else begin
                        nxt = ST_WRITE;
                    end
                end
            end
            ST_WRITE, ST_READ, ST_IGNORE: begin
                if (!cs) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_wr || reg_rd) begin
                reg_addr <= reg_addr + 1'b1;
            end
            if (cs && byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        if (cmd_valid(rx_byte)) begin
                            reg_addr <= rx_byte[ADDR_W-1:0];
                            reg_rd   <= rx_byte[CMD_RD_BIT];
                        end
                    end
                    ST_WRITE: begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= rx_byte;
                    end
                    ST_READ: begin
                        reg_rd <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0]  raw_in;
    logic [NSYNC-1:0]  syn_in;
    logic              sck_s;
    logic              cs_s;
    logic              mosi_s;
    logic              sck_prev;
    logic              sck_rise;
    logic              sck_fall;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    spireg_state_e     fsm_state;

    assign raw_in = {spi_sck, spi_cs, spi_mosi};

    spireg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign sck_s  = syn_in[2];
    assign cs_s   = syn_in[1];
    assign mosi_s = syn_in[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
        end
    end

    assign sck_rise = cs_s &  sck_s & ~sck_prev;
    assign sck_fall = cs_s & ~sck_s &  sck_prev;

    spireg_rx #(.W(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (~cs_s),
        .sample (sck_rise),
        .din    (mosi_s),
        .byte_q (rx_byte),
        .done   (byte_done)
    );

    spireg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs_s),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .state     (fsm_state),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd)
    );

    spireg_tx #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~cs_s),
        .load      (reg_rd),
        .load_data (reg_rdata),
        .shift     (sck_fall),
        .enable    (fsm_state == ST_READ),
        .dout      (spi_miso)
    );

endmodule

// File: rtl/spireg_checker.sv
module spireg_checker
    import spireg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input spireg_state_e     st,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              spi_miso
);

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    a_r6_addr_step_wr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    a_r6_addr_step_rd: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    a_r4_wr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(st) == ST_WRITE);

    a_r5_rd_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> ($past(st) == ST_CMD || $past(st) == ST_READ));

    a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IGNORE |-> (!reg_wr && !reg_rd && !spi_miso));

    a_r2_idle_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE |-> !spi_miso);

    a_r9_cmd_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_CMD |-> !spi_miso);

endmodule

bind spireg_slave spireg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (fsm_state),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .spi_miso (spi_miso)
);

// File: tb/sim_spireg_slave.sv
`timescale 1ns/1ps
module sim_spireg_slave;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_rdata;

    logic [7:0] mem [16];
    logic [7:0] expv [16];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int both_cnt = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spireg_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs    (cs),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
        end else begin
            if (reg_wr) begin
                mem[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
            if (reg_wr && reg_rd) both_cnt <= both_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            tick(HALF);
            sck = 1'b1;
            rx[i] = miso;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic open_frame();
        cs = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic close_frame();
        tick(HALF);
        cs = 1'b0;
        tick(2 * HALF + 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int w0;
        int r0;
        for (int i = 0; i < 16; i++) expv[i] = 8'h00;

        // R1: reset state
        tick(6);
        chk("R1 miso in reset", miso, 0);
        chk("R1 reg_wr in reset", reg_wr, 0);
        chk("R1 reg_rd in reset", reg_rd, 0);
        rst_n = 1'b1;
        tick(4);

        // R2: SCK and MOSI activity with chip select low
        w0 = wr_cnt; r0 = rd_cnt;
        for (int i = 0; i < 16; i++) begin
            mosi = i[0];
            tick(HALF); sck = 1'b1;
            tick(HALF); sck = 1'b0;
        end
        tick(8);
        chk("R2 no strobes while deselected", (wr_cnt - w0) + (rd_cnt - r0), 0);
        chk("R2 miso low while deselected", miso, 0);

        // R4: single-byte write to each address
        for (int a = 0; a < 16; a++) begin
            logic [7:0] v;
            v = 8'((a * 37 + 11) & 8'hFF);
            w0 = wr_cnt;
            open_frame();
            xfer(8'h10 | 8'(a), rx);
            xfer(v, rx);
            close_frame();
            expv[a] = v;
            chk("R4 single write data", mem[a], v);
            chk("R4 single write count", wr_cnt - w0, 1);
        end

        // R5, R9: single-byte read from each address
        for (int a = 0; a < 16; a++) begin
            open_frame();
            xfer(8'h90 | 8'(a), rx);
            chk("R9 miso during command", rx, 0);
            xfer(8'h00, rx);
            close_frame();
            chk("R5 single read data", rx, expv[a]);
        end

        // R6: write burst crossing the 0xF -> 0x0 wrap
        open_frame();
        xfer(8'h1C, rx);
        for (int i = 0; i < 8; i++) begin
            xfer(8'hC0 + 8'(i), rx);
            expv[(12 + i) % 16] = 8'hC0 + 8'(i);
        end
        close_frame();
        for (int a = 0; a < 16; a++) chk("R6 burst write image", mem[a], expv[a]);

        // R6: read bursts from every start address, longer than the bank
        for (int s = 0; s < 16; s++) begin
            open_frame();
            xfer(8'h90 | 8'(s), rx);
            for (int i = 0; i < 17; i++) begin
                xfer(8'hFF, rx);
                chk("R6 burst read data", rx, expv[(s + i) % 16]);
            end
            close_frame();
        end

        // R3, R7: sweep of every command value
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            logic [7:0] d;
            logic [7:0] rc;
            cb = 8'(c);
            d = cb ^ 8'h5A;
            w0 = wr_cnt; r0 = rd_cnt;
            open_frame();
            xfer(cb, rc);
            xfer(d, rx);
            close_frame();
            if (cb[6:4] != 3'b001) begin
                chk("R7 invalid command strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
                chk("R7 invalid command miso", rx, 0);
            end else if (cb[7]) begin
                chk("R3 valid read data", rx, expv[cb[3:0]]);
                chk("R3 valid read no write", wr_cnt - w0, 0);
            end else begin
                expv[cb[3:0]] = d;
                chk("R3 valid write data", mem[cb[3:0]], d);
                chk("R3 valid write count", wr_cnt - w0, 1);
            end
        end

        // R8: data byte cut short by chip select
        w0 = wr_cnt;
        open_frame();
        xfer(8'h13, rx);
        bits(8'hFF, 5, rx);
        close_frame();
        chk("R8 partial byte no write", wr_cnt - w0, 0);
        open_frame();
        xfer(8'h93, rx);
        xfer(8'h00, rx);
        close_frame();
        chk("R8 register kept after partial byte", rx, expv[3]);

        // R10: strobes never coincide over the whole run
        chk("R10 write and read strobes exclusive", both_cnt, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule